// File: doc/BRIEF.md
# System Control Register File

This block is a small bank of control and status words for a secure microcontroller subsystem. A host reaches it through a 32-bit register bus over a 4 KB window. Each word is selected by address bits 11:2; the two lowest address bits are not decoded. Each access is presented for one cycle with `bus_valid` high. Read data and the error flag come back from registers on the following cycle.

The file holds a secure-debug flag word, which is changed through separate set and clear addresses. It also holds reset cause and mask words, a retention word, and boot vector words, one of which can be locked. Further words cover a CPU hold word whose falling bits release CPUs, clock and security scratch words, power-domain sense words, a lock-gated power control word, and a fixed set of identification bytes. A software reset request leaves the block as a one-cycle pulse.

The parameter `VARIANT` picks one of three address maps. Generation 0 is the smallest. Generation 1 has two CPUs and the widest map. Generation 2 has one CPU, moves some words to new offsets and adds the locks.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset, reads return these values: 0x100 = 1, 0x200 = 0x7F, 0x110 = BOOT0_RST, 0x114 = BOOT1_RST (both default 0x10000000), the CPU hold word = WAIT_RST (default 0), 0x1FC = 0x3. Every other stored word reads 0, and all output pulses are low.
- R2: A write to 0x004 ORs the data into the debug flag word. A write to 0x008 clears each flag whose data bit is 1. The flags are read at 0x000, while reads of 0x004 and 0x008 return 0.
- R3: A write to 0x108 with data bit 9 set raises `sys_reset_req` for exactly the one cycle after the access. Data with bit 9 clear raises nothing, and a read of 0x108 returns 0.
- R4: A write to the CPU hold word that turns bit i from 1 to 0 raises `cpu_release[i]` for one cycle. Generations 0 and 1 use bits 0 and 1. Generation 2 uses bit 0 only, and `cpu_release[1]` stays low there.
- R5: In generation 2, bit 0 of the word at 0x110 is a lock: once the stored bit is 1, writes to 0x110 are ignored. There `boot_vec0` is the stored word with bits 6:0 forced to 0. In the other generations `boot_vec0` is the whole stored word.
- R6: In generation 2 the power control word at 0x1FC accepts a write only while its stored bit 0 is 1.
- R7: In generation 2, 0x120 is the CPU hold word and 0x124 is the NMI enable word, while 0x114, 0x118 and 0x11C are reserved.
- R8: In generation 0, these offsets are reserved: 0x00C–0x018, 0x114, 0x124, 0x1FC and all sense offsets. Offset 0x11C there reads 0, ignores writes and is not an error.
- R9: Offsets 0xFD0–0xFFC read, in ascending order, the bytes 04 00 00 00 54 B8 0B 00 0D F0 05 B1, each zero-extended to 32 bits.
- R10: Any access to a reserved or unlisted offset reads 0, changes no state, and raises `bus_err` in the cycle after. Accesses to defined offsets never raise it.
- R11: Writes to 0x000 and to the identification offsets leave their read values unchanged.
- R12: Every other defined word stores all 32 written bits and returns them on a later read. Read data appears in the cycle after the access, and `bus_rdata` is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Reserved-offset flag, one cycle, registered |
| sys_reset_req | output | 1 | Software reset request pulse |
| cpu_release | output | 2 | Per-CPU release pulses |
| boot_vec0 | output | 32 | Boot vector for CPU 0 |
| boot_vec1 | output | 32 | Boot vector for CPU 1 |

## Verification
The single-pulse check on `sys_reset_req` takes for granted that two writes to 0x108 with bit 9 set never come in consecutive cycles. The lock checks take for granted that reset values leave both lock bits in their default state. The stimulus keeps within both conditions: it always leaves an idle cycle between accesses and uses the default reset parameters. The bench drives three copies of the block, one per generation, from the same bus. It sweeps every word offset twice, first to read reset values and then to read back after a fill write of a pattern that has bits 0, 1 and 9 clear. This keeps the sweep from setting locks, releasing CPUs or requesting resets, and the directed sequences then test those effects on their own.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int WORD_W  = ADDR_W - 2;
  localparam int MAX_CPU = 2;

  localparam int VAR_GEN0 = 0;
  localparam int VAR_GEN1 = 1;
  localparam int VAR_GEN2 = 2;

  localparam int SWRST_BIT = 9;
  localparam int LOCK_BIT  = 0;
  localparam int UNLK_BIT  = 0;
  localparam int VEC_LSB   = 7;

  typedef logic [WORD_W-1:0] word_t;

  // word offsets (byte offset / 4)
  localparam word_t W_DBG_STAT = 10'h000;
  localparam word_t W_DBG_SET  = 10'h001;
  localparam word_t W_DBG_CLR  = 10'h002;
  localparam word_t W_SEC      = 10'h003;
  localparam word_t W_FDIV     = 10'h004;
  localparam word_t W_SDIV     = 10'h005;
  localparam word_t W_CFORCE   = 10'h006;
  localparam word_t W_SYND     = 10'h040;
  localparam word_t W_RMASK    = 10'h041;
  localparam word_t W_SWRST    = 10'h042;
  localparam word_t W_RETAIN   = 10'h043;
  localparam word_t W_BOOT0    = 10'h044;
  localparam word_t W_BOOT1    = 10'h045;
  localparam word_t W_WAIT     = 10'h046;
  localparam word_t W_NMI      = 10'h047;
  localparam word_t W_WIC      = 10'h048;
  localparam word_t W_EW       = 10'h049;
  localparam word_t W_PWR      = 10'h07F;
  localparam word_t W_SNS_SYS  = 10'h080;
  localparam word_t W_SNS_CPU  = 10'h081;
  localparam word_t W_SNS_M0   = 10'h083;
  localparam word_t W_SNS_M1   = 10'h084;
  localparam word_t W_SNS_M2   = 10'h085;
  localparam word_t W_SNS_M3   = 10'h086;
  localparam word_t W_ID_FIRST = 10'h3F4;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_ZERO_RO, SEL_ID, SEL_DBG_STAT, SEL_DBG_SET, SEL_DBG_CLR,
    SEL_SWRST, SEL_BOOT0, SEL_WAIT, SEL_PWR,
    SEL_SEC, SEL_FDIV, SEL_SDIV, SEL_CFORCE, SEL_SYND, SEL_RMASK, SEL_RETAIN,
    SEL_BOOT1, SEL_NMI, SEL_WIC, SEL_EW,
    SEL_SNS_SYS, SEL_SNS_CPU, SEL_SNS_M0, SEL_SNS_M1, SEL_SNS_M2, SEL_SNS_M3
  } reg_sel_e;

  // plain read/write words occupy a contiguous stretch of the select code
  localparam int PLAIN_BASE = int'(SEL_SEC);
  localparam int NPLAIN     = int'(SEL_SNS_M3) - PLAIN_BASE + 1;
  localparam int PIDX_W     = $clog2(NPLAIN);

  function automatic logic [DATA_W-1:0] plain_reset(int idx, logic [DATA_W-1:0] boot1_rst);
    if (idx == int'(SEL_SYND) - PLAIN_BASE)         return 32'h1;
    else if (idx == int'(SEL_SNS_SYS) - PLAIN_BASE) return 32'h7F;
    else if (idx == int'(SEL_BOOT1) - PLAIN_BASE)   return boot1_rst;
    else                                            return '0;
  endfunction
endpackage

// File: rtl/sys_ctrl_decode.sv
module sys_ctrl_decode
  import sys_ctrl_pkg::*;
#(
  parameter int VARIANT = VAR_GEN2
) (
  input  word_t    word,
  output reg_sel_e sel
);
  localparam bit HAS_WIDE = (VARIANT != VAR_GEN0);
  localparam bit IS_NEW   = (VARIANT == VAR_GEN2);
  localparam bit IS_MID   = (VARIANT == VAR_GEN1);

  always_comb begin
    sel = SEL_NONE;
    case (word)
      W_DBG_STAT: sel = SEL_DBG_STAT;
      W_DBG_SET:  sel = SEL_DBG_SET;
      W_DBG_CLR:  sel = SEL_DBG_CLR;
      W_SEC:      sel = HAS_WIDE ? SEL_SEC    : SEL_NONE;
      W_FDIV:     sel = HAS_WIDE ? SEL_FDIV   : SEL_NONE;
      W_SDIV:     sel = HAS_WIDE ? SEL_SDIV   : SEL_NONE;
      W_CFORCE:   sel = HAS_WIDE ? SEL_CFORCE : SEL_NONE;
      W_SYND:     sel = SEL_SYND;
      W_RMASK:    sel = SEL_RMASK;
      W_SWRST:    sel = SEL_SWRST;
      W_RETAIN:   sel = SEL_RETAIN;
      W_BOOT0:    sel = SEL_BOOT0;
      W_BOOT1:    sel = IS_MID ? SEL_BOOT1 : SEL_NONE;
      W_WAIT:     sel = IS_NEW ? SEL_NONE : SEL_WAIT;
      W_NMI: begin
        if (IS_MID)       sel = SEL_NMI;
        else if (!IS_NEW) sel = SEL_ZERO_RO;
      end
      W_WIC:      sel = IS_NEW ? SEL_WAIT : SEL_WIC;
      W_EW: begin
        if (IS_NEW)      sel = SEL_NMI;
        else if (IS_MID) sel = SEL_EW;
      end
      W_PWR:      sel = IS_NEW ? SEL_PWR : SEL_NONE;
      W_SNS_SYS:  sel = HAS_WIDE ? SEL_SNS_SYS : SEL_NONE;
      W_SNS_CPU:  sel = IS_NEW ? SEL_SNS_CPU : SEL_NONE;
      W_SNS_M0:   sel = IS_MID ? SEL_SNS_M0 : SEL_NONE;
      W_SNS_M1:   sel = IS_MID ? SEL_SNS_M1 : SEL_NONE;
      W_SNS_M2:   sel = HAS_WIDE ? SEL_SNS_M2 : SEL_NONE;
      W_SNS_M3:   sel = HAS_WIDE ? SEL_SNS_M3 : SEL_NONE;
      default: begin
        if (word >= W_ID_FIRST) sel = SEL_ID;
      end
    endcase
  end
endmodule

// File: rtl/sys_ctrl_id.sv
module sys_ctrl_id
  import sys_ctrl_pkg::*;
(
  input  word_t             word,
  output logic [DATA_W-1:0] id_word
);
  word_t idx;
  logic  unused_idx_hi;

  assign idx           = word - W_ID_FIRST;
  assign unused_idx_hi = ^idx[WORD_W-1:4];

  always_comb begin
    case (idx[3:0])
      4'd0:    id_word = 32'h04;
      4'd4:    id_word = 32'h54;
      4'd5:    id_word = 32'hB8;
      4'd6:    id_word = 32'h0B;
      4'd8:    id_word = 32'h0D;
      4'd9:    id_word = 32'hF0;
      4'd10:   id_word = 32'h05;
      4'd11:   id_word = 32'hB1;
      default: id_word = 32'h00;
    endcase
  end
endmodule

// File: rtl/sys_ctrl_store.sv
module sys_ctrl_store
  import sys_ctrl_pkg::*;
#(
  parameter int                VARIANT   = VAR_GEN2,
  parameter logic [DATA_W-1:0] BOOT0_RST = 32'h1000_0000,
  parameter logic [DATA_W-1:0] BOOT1_RST = 32'h1000_0000,
  parameter logic [DATA_W-1:0] WAIT_RST  = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  id_word,
  output logic [DATA_W-1:0]  rd_word,
  output logic [MAX_CPU-1:0] release_hit,
  output logic [DATA_W-1:0]  boot0_word,
  output logic [DATA_W-1:0]  boot1_word,
  output logic [DATA_W-1:0]  pwr_word
);
  localparam int NCPU    = (VARIANT == VAR_GEN2) ? 1 : 2;
  localparam bit HAS_LCK = (VARIANT == VAR_GEN2);

  logic [DATA_W-1:0] dbg_q, boot0_q, wait_q, pwr_q;
  logic [DATA_W-1:0] plain_q [NPLAIN];
  logic [PIDX_W-1:0] plain_idx;
  logic              in_plain;
  logic              boot0_locked;

  assign boot0_locked = HAS_LCK && boot0_q[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q <= '0;
    end else if (wr_en && sel == SEL_DBG_SET) begin
      dbg_q <= dbg_q | wdata;
    end else if (wr_en && sel == SEL_DBG_CLR) begin
      dbg_q <= dbg_q & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot0_q <= BOOT0_RST;
    end else if (wr_en && sel == SEL_BOOT0 && !boot0_locked) begin
      boot0_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= WAIT_RST;
    end else if (wr_en && sel == SEL_WAIT) begin
      wait_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= 32'h3;
    end else if (wr_en && sel == SEL_PWR && pwr_q[UNLK_BIT]) begin
      pwr_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NPLAIN; g++) begin
      if (rst) begin
        plain_q[g] <= plain_reset(g, BOOT1_RST);
      end else if (wr_en && int'(sel) == PLAIN_BASE + g) begin
        plain_q[g] <= wdata;
      end
    end
  end

  // falling hold bits release their CPU; unused lanes stay quiet
  for (genvar i = 0; i < MAX_CPU; i++) begin : g_rel
    if (i < NCPU) begin : g_on
      assign release_hit[i] = wr_en && sel == SEL_WAIT && wait_q[i] && !wdata[i];
    end else begin : g_off
      assign release_hit[i] = 1'b0;
    end
  end

  assign in_plain  = (int'(sel) >= PLAIN_BASE) && (int'(sel) < PLAIN_BASE + NPLAIN);
  assign plain_idx = PIDX_W'(int'(sel) - PLAIN_BASE);

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_DBG_STAT: rd_word = dbg_q;
      SEL_BOOT0:    rd_word = boot0_q;
      SEL_WAIT:     rd_word = wait_q;
      SEL_PWR:      rd_word = pwr_q;
      SEL_ID:       rd_word = id_word;
      default: begin
        if (in_plain) rd_word = plain_q[plain_idx];
      end
    endcase
  end

  assign boot0_word = boot0_q;
  assign boot1_word = plain_q[int'(SEL_BOOT1) - PLAIN_BASE];
  assign pwr_word   = pwr_q;
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
#(
  parameter int                VARIANT   = VAR_GEN2,
  parameter logic [DATA_W-1:0] BOOT0_RST = 32'h1000_0000,
  parameter logic [DATA_W-1:0] BOOT1_RST = 32'h1000_0000,
  parameter logic [DATA_W-1:0] WAIT_RST  = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               sys_reset_req,
  output logic [MAX_CPU-1:0] cpu_release,
  output logic [DATA_W-1:0]  boot_vec0,
  output logic [DATA_W-1:0]  boot_vec1
);
  word_t             word;
  reg_sel_e          sel;
  logic [DATA_W-1:0] id_word, rd_word, boot0_word, boot1_word, pwr_word;
  logic [MAX_CPU-1:0] release_hit;
  logic              wr_en, rd_en;
  logic              unused_lo;

  assign word      = bus_addr[ADDR_W-1:2];
  assign unused_lo = ^bus_addr[1:0];
  assign wr_en     = bus_valid && bus_write;
  assign rd_en     = bus_valid && !bus_write;

  sys_ctrl_decode #(.VARIANT(VARIANT)) decode_i (
    .word (word),
    .sel  (sel)
  );

  sys_ctrl_id id_i (
    .word    (word),
    .id_word (id_word)
  );

  sys_ctrl_store #(
    .VARIANT   (VARIANT),
    .BOOT0_RST (BOOT0_RST),
    .BOOT1_RST (BOOT1_RST),
    .WAIT_RST  (WAIT_RST)
  ) store_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .sel         (sel),
    .wdata       (bus_wdata),
    .id_word     (id_word),
    .rd_word     (rd_word),
    .release_hit (release_hit),
    .boot0_word  (boot0_word),
    .boot1_word  (boot1_word),
    .pwr_word    (pwr_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata     <= '0;
      bus_err       <= 1'b0;
      sys_reset_req <= 1'b0;
      cpu_release   <= '0;
    end else begin
      bus_rdata     <= rd_en ? rd_word : '0;
      bus_err       <= bus_valid && (sel == SEL_NONE);
      sys_reset_req <= wr_en && (sel == SEL_SWRST) && bus_wdata[SWRST_BIT];
      cpu_release   <= release_hit;
    end
  end

  if (VARIANT == VAR_GEN2) begin : g_vec_masked
    assign boot_vec0 = {boot0_word[DATA_W-1:VEC_LSB], {VEC_LSB{1'b0}}};
  end else begin : g_vec_full
    assign boot_vec0 = boot0_word;
  end
  assign boot_vec1 = boot1_word;
endmodule

// File: rtl/sys_ctrl_checker.sv
module sys_ctrl_checker
  import sys_ctrl_pkg::*;
#(
  parameter int VARIANT = VAR_GEN2
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_err,
  input logic               sys_reset_req,
  input logic [MAX_CPU-1:0] cpu_release,
  input logic [DATA_W-1:0]  boot0_word,
  input logic [DATA_W-1:0]  pwr_word
);
  localparam bit IS_NEW = (VARIANT == VAR_GEN2);

  assert_swreset_cause_R3: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(bus_valid && bus_write &&
                            bus_addr[ADDR_W-1:2] == W_SWRST && bus_wdata[SWRST_BIT]));

  assert_swreset_single_R3: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> !sys_reset_req);

  assert_release_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (|cpu_release) |-> $past(bus_valid && bus_write));

  assert_boot_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (IS_NEW && $past(boot0_word[LOCK_BIT])) |-> $stable(boot0_word));

  assert_pwr_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (IS_NEW && !$past(pwr_word[UNLK_BIT])) |-> $stable(pwr_word));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid));

  assert_rdata_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata != '0) |-> $past(bus_valid && !bus_write));
endmodule

bind sys_ctrl_regs sys_ctrl_checker #(.VARIANT(VARIANT)) checker_i (
  .clk           (clk),
  .rst           (rst),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .bus_err       (bus_err),
  .sys_reset_req (sys_reset_req),
  .cpu_release   (cpu_release),
  .boot0_word    (boot0_word),
  .pwr_word      (pwr_word)
);

// File: tb/sys_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module sys_ctrl_regs_tb_top;
  localparam logic [31:0] FILL = 32'h3C5A_2C70;  // bits 0, 1 and 9 clear

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr  = '0;
  logic [31:0] bus_wdata = '0;

  logic [31:0] rd_w   [3];
  logic        err_w  [3];
  logic        req_w  [3];
  logic [1:0]  rel_w  [3];
  logic [31:0] vec0_w [3];
  logic [31:0] vec1_w [3];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sys_ctrl_regs #(.VARIANT(0)) dut_old_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[0]),
    .bus_err(err_w[0]), .sys_reset_req(req_w[0]), .cpu_release(rel_w[0]),
    .boot_vec0(vec0_w[0]), .boot_vec1(vec1_w[0]));

  sys_ctrl_regs #(.VARIANT(1)) dut_mid_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[1]),
    .bus_err(err_w[1]), .sys_reset_req(req_w[1]), .cpu_release(rel_w[1]),
    .boot_vec0(vec0_w[1]), .boot_vec1(vec1_w[1]));

  sys_ctrl_regs #(.VARIANT(2)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[2]),
    .bus_err(err_w[2]), .sys_reset_req(req_w[2]), .cpu_release(rel_w[2]),
    .boot_vec0(vec0_w[2]), .boot_vec1(vec1_w[2]));

  task automatic chk(string tag, int v, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gen%0d %s: actual %h expected %h", tag, v, what, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] id_byte(int k);
    case (k)
      0: return 32'h04;  4: return 32'h54;  5: return 32'hB8;  6: return 32'h0B;
      8: return 32'h0D;  9: return 32'hF0; 10: return 32'h05; 11: return 32'hB1;
      default: return 32'h00;
    endcase
  endfunction

  // {err, data} expected from a read of byte offset a in generation v
  function automatic logic [32:0] model(int v, int a, bit filled);
    logic        e = 1'b0;
    logic [31:0] d = '0;
    case (a)
      'h000, 'h004, 'h008, 'h108: d = '0;
      'h00C, 'h010, 'h014, 'h018: if (v == 0) e = 1; else d = filled ? FILL : 0;
      'h100: d = filled ? FILL : 32'h1;
      'h104, 'h10C, 'h120: d = filled ? FILL : 0;
      'h110: d = filled ? FILL : 32'h1000_0000;
      'h114: if (v == 1) d = filled ? FILL : 32'h1000_0000; else e = 1;
      'h118: if (v == 2) e = 1; else d = filled ? FILL : 0;
      'h11C: if (v == 2) e = 1; else if (v == 1) d = filled ? FILL : 0;
      'h124: if (v == 0) e = 1; else d = filled ? FILL : 0;
      'h1FC: if (v == 2) d = filled ? FILL : 32'h3; else e = 1;
      'h200: if (v == 0) e = 1; else d = filled ? FILL : 32'h7F;
      'h204: if (v == 2) d = filled ? FILL : 0; else e = 1;
      'h20C, 'h210: if (v == 1) d = filled ? FILL : 0; else e = 1;
      'h214, 'h218: if (v == 0) e = 1; else d = filled ? FILL : 0;
      default: if (a >= 'hFD0) d = id_byte((a - 'hFD0) / 4); else e = 1;
    endcase
    return {e, d};
  endfunction

  function automatic string tag_for(int v, int a, logic e, bit filled);
    if (a >= 'hFD0) return filled ? "R11" : "R9";
    if (e) begin
      if (v == 2 && (a == 'h114 || a == 'h118 || a == 'h11C)) return "R7";
      if (v == 0) return "R8";
      return "R10";
    end
    if (v == 2 && (a == 'h120 || a == 'h124)) return "R7";
    if (v == 0 && a == 'h11C) return "R8";
    if (a == 'h108) return "R3";
    if (a == 'h004 || a == 'h008) return "R2";
    if (a == 'h000 && filled) return "R11";
    return filled ? "R12" : "R1";
  endfunction

  task automatic sweep_read(bit filled);
    for (int w = 0; w < 1024; w++) begin
      access(1'b0, 12'(w * 4), '0);
      for (int v = 0; v < 3; v++) begin
        logic [32:0] m;
        string t;
        m = model(v, w * 4, filled);
        t = tag_for(v, w * 4, m[32], filled);
        chk(t, v, $sformatf("rdata @%h", w * 4), rd_w[v], m[31:0]);
        chk(m[32] ? "R10" : t, v, $sformatf("err @%h", w * 4), 32'(err_w[v]), 32'(m[32]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int v = 0; v < 3; v++) begin
      chk("R1", v, "boot_vec0", vec0_w[v], 32'h1000_0000);
      chk("R1", v, "boot_vec1", vec1_w[v], 32'h1000_0000);
      chk("R1", v, "release", 32'(rel_w[v]), 0);
      chk("R1", v, "reset_req", 32'(req_w[v]), 0);
      chk("R1", v, "err", 32'(err_w[v]), 0);
      chk("R1", v, "rdata", rd_w[v], 0);
    end

    // reset values and map of every offset
    sweep_read(1'b0);

    // fill every offset, then read everything back
    for (int w = 0; w < 1024; w++) begin
      access(1'b1, 12'(w * 4), FILL);
      for (int v = 0; v < 3; v++) begin
        logic [32:0] m;
        m = model(v, w * 4, 1'b0);
        chk("R10", v, $sformatf("write err @%h", w * 4), 32'(err_w[v]), 32'(m[32]));
        chk("R12", v, "rdata after write", rd_w[v], 0);
        chk("R4", v, "no release on fill", 32'(rel_w[v]), 0);
        chk("R3", v, "no reset on fill", 32'(req_w[v]), 0);
      end
    end
    sweep_read(1'b1);

    // R2 set/clear pair
    do_reset();
    access(1'b1, 12'h004, 32'h0000_00F3);
    access(1'b1, 12'h004, 32'h0000_0100);
    access(1'b0, 12'h000, '0);
    for (int v = 0; v < 3; v++) chk("R2", v, "flags after set", rd_w[v], 32'h1F3);
    access(1'b1, 12'h008, 32'h0000_0031);
    access(1'b0, 12'h000, '0);
    for (int v = 0; v < 3; v++) chk("R2", v, "flags after clear", rd_w[v], 32'h1C2);
    access(1'b1, 12'h000, 32'hFFFF_FFFF);
    access(1'b0, 12'h000, '0);
    for (int v = 0; v < 3; v++) chk("R11", v, "flags after direct write", rd_w[v], 32'h1C2);

    // R3 software reset pulse
    access(1'b1, 12'h108, 32'hFFFF_FDFF);
    for (int v = 0; v < 3; v++) chk("R3", v, "req bit9 clear", 32'(req_w[v]), 0);
    access(1'b1, 12'h108, 32'h0000_0200);
    for (int v = 0; v < 3; v++) chk("R3", v, "req bit9 set", 32'(req_w[v]), 1);
    @(negedge clk);
    for (int v = 0; v < 3; v++) chk("R3", v, "req one cycle", 32'(req_w[v]), 0);

    // R4 release on falling hold bits
    access(1'b1, 12'h118, 32'h3);
    for (int v = 0; v < 3; v++) chk("R4", v, "hold set", 32'(rel_w[v]), 0);
    chk("R7", 2, "0x118 reserved err", 32'(err_w[2]), 1);
    access(1'b1, 12'h120, 32'h3);
    for (int v = 0; v < 3; v++) chk("R4", v, "hold set 0x120", 32'(rel_w[v]), 0);
    access(1'b1, 12'h118, 32'h1);
    chk("R4", 0, "cpu1 release", 32'(rel_w[0]), 32'h2);
    chk("R4", 1, "cpu1 release", 32'(rel_w[1]), 32'h2);
    chk("R4", 2, "no release", 32'(rel_w[2]), 0);
    access(1'b1, 12'h120, 32'h0);
    chk("R4", 0, "wic no release", 32'(rel_w[0]), 0);
    chk("R4", 1, "wic no release", 32'(rel_w[1]), 0);
    chk("R4", 2, "single cpu release", 32'(rel_w[2]), 32'h1);
    access(1'b1, 12'h118, 32'h0);
    chk("R4", 0, "cpu0 release", 32'(rel_w[0]), 32'h1);
    chk("R4", 1, "cpu0 release", 32'(rel_w[1]), 32'h1);
    chk("R4", 2, "no release", 32'(rel_w[2]), 0);
    @(negedge clk);
    for (int v = 0; v < 3; v++) chk("R4", v, "release one cycle", 32'(rel_w[v]), 0);

    // R5 boot vector lock and masking
    access(1'b1, 12'h110, 32'h2000_00FF);
    chk("R5", 0, "vec0", vec0_w[0], 32'h2000_00FF);
    chk("R5", 1, "vec0", vec0_w[1], 32'h2000_00FF);
    chk("R5", 2, "vec0 masked", vec0_w[2], 32'h2000_0080);
    access(1'b1, 12'h110, 32'h3000_0000);
    chk("R5", 0, "vec0 rewrite", vec0_w[0], 32'h3000_0000);
    chk("R5", 1, "vec0 rewrite", vec0_w[1], 32'h3000_0000);
    chk("R5", 2, "vec0 locked", vec0_w[2], 32'h2000_0080);
    access(1'b0, 12'h110, '0);
    chk("R5", 2, "locked readback", rd_w[2], 32'h2000_00FF);

    // R6 power control lock
    access(1'b1, 12'h1FC, 32'h2);
    access(1'b0, 12'h1FC, '0);
    chk("R6", 2, "pwr after unlock clear", rd_w[2], 32'h2);
    chk("R6", 0, "pwr reserved", 32'(err_w[0]), 1);
    access(1'b1, 12'h1FC, 32'h3);
    access(1'b0, 12'h1FC, '0);
    chk("R6", 2, "pwr locked", rd_w[2], 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule